// File: doc/BRIEF.md
# Debug Break Condition Comparator

This block is one break channel of an on-chip debug unit. Software programs a channel condition, and optionally a data condition, through a small register port. The core then reports each bus access to the channel with its kind (instruction fetch or operand access), direction, operand size, a 64-bit data value, a flag saying whether that value is present, and an instruction class. When the access satisfies every part of the programmed condition, the channel raises a break request on the next clock cycle. The request lasts for exactly one cycle.

The data comparison is masked bit by bit against a 32-bit match value. A 64-bit access is compared one 32-bit half at a time, and both halves must agree. Cache-invalidate instructions reach the channel as longword operand writes that carry no data. Prefetch and cache-writeback instructions reach it as longword operand reads that carry no data. Because these accesses have no data value, a condition that asks for a data match never fires on them.

Top module: `dbg_brk_top`

## Requirements
- R1: After reset, all four registers read back as 0 and `brkReq` is 0.
- R2: The register map is as follows. Address 0 is the channel condition: bits 7:6 bus select, bits 5:4 kind select, bit 3 reserved, bits 2:1 direction select, bit 0 enable. Address 1 is the data condition: bit 0 data-match enable, bits 2:1 required size, and all other bits read 0. Address 2 is the 32-bit match value. Address 3 is the 32-bit mask. The reserved bit 3 at address 0 always reads 0, and writing to it has no effect.
- R3: While the enable bit is 0, `brkReq` stays 0 whatever the other fields hold and whatever access arrives.
- R4: The kind select works as follows. 01 matches instruction fetches only, 10 matches operand accesses only, and 00 or 11 match both kinds.
- R5: The direction select works as follows. 01 matches reads only, 10 matches writes only, and 00 or 11 match both. It is applied to operand accesses only, and instruction fetches ignore it.
- R6: An operand access matches only while the bus select is 00. Any other bus-select value blocks the match of an operand access. Instruction fetches ignore this field.
- R7: With data matching enabled, a mask bit of 1 excludes that data bit from the comparison, and a mask bit of 0 requires it to equal the match value. Accesses that are not 64 bits wide compare data bits 31:0 only.
- R8: For a 64-bit access (size 11), bits 63:32 and bits 31:0 are each compared under the mask, and the data condition holds only when both halves agree.
- R9: With data matching enabled, an access matches only if its data is present and its size equals the required size. The size encoding is 00 byte, 01 word, 10 longword, 11 quadword.
- R10: The instruction class controls how an access is treated. Class 01 (cache invalidate) is treated as a longword operand write with no data. Class 10 (prefetch or cache writeback) is treated as a longword operand read with no data. Classes 00 and 11 use the reported fields unchanged.
- R11: The `brkReq` output is registered. It is high for exactly one cycle, in the cycle after the clock edge that samples a matching access with `accValid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for a write or a read |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for the register at `regAddr` (combinational) |
| accValid | input | 1 | An access is reported in this cycle |
| accIsFetch | input | 1 | 1 for an instruction fetch, 0 for an operand access |
| accIsWrite | input | 1 | 1 for a write, 0 for a read |
| accSize | input | 2 | Operand size: 00 byte, 01 word, 10 longword, 11 quadword |
| accData | input | 64 | Access data value |
| accDataValid | input | 1 | The data value is present |
| accClass | input | 2 | Instruction class: 00 or 11 ordinary, 01 invalidate, 10 prefetch or writeback |
| brkReq | output | 1 | Break request, one cycle per matching access |

## Verification
Random configurations and random accesses are mixed together. Accesses whose data is built from the match value, with flips allowed only under mask bits, are set against accesses with free random data. This shows whether the masked comparison is right and whether it is actually applied. Directed cases then target specific confusions:
- A quadword that matches in only one half separates a both-halves check from a single-half check.
- Invalidate and prefetch classes sent under read-only, write-only and data-match conditions show whether the reclassification happens.
- Fetches sent with a reserved bus select or a restrictive direction select show that those fields apply to operand accesses only.
- A disabled channel holding an otherwise matching condition, and a write of all ones to the condition register, cover the enable and the reserved bit.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  localparam logic [1:0] SZ_LONG = 2'b10;
  localparam logic [1:0] SZ_QUAD = 2'b11;

  localparam logic [1:0] CLS_INVAL = 2'b01;
  localparam logic [1:0] CLS_PREF  = 2'b10;

  localparam logic [ADDR_W-1:0] A_COND  = 2'd0;
  localparam logic [ADDR_W-1:0] A_DCOND = 2'd1;
  localparam logic [ADDR_W-1:0] A_MDATA = 2'd2;
  localparam logic [ADDR_W-1:0] A_MMASK = 2'd3;

  typedef struct packed {
    logic loadData;
    logic loadMask;
  } dpStrobe_t;
endpackage

// File: rtl/dbg_brk_dp.sv
module dbg_brk_dp
  import dbg_brk_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpStrobe_t      strb,
  input  logic [W-1:0]   wrData,
  input  logic [2*W-1:0] accData,
  output logic [W-1:0]   matchData,
  output logic [W-1:0]   matchMask,
  output logic [1:0]     halfHit
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchData <= '0;
      matchMask <= '0;
    end else begin
      if (strb.loadData) matchData <= wrData;
      if (strb.loadMask) matchMask <= wrData;
    end
  end

  // One masked comparator per 32-bit half of the access data
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [W-1:0] diff;
    assign diff = (accData[h*W +: W] ^ matchData) & ~matchMask;
    assign halfHit[h] = (diff == '0);
  end
endmodule

// File: rtl/dbg_brk_ctrl.sv
module dbg_brk_ctrl
  import dbg_brk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        wrByte,
  output dpStrobe_t         strb,
  output logic [7:0]        condReg,
  output logic [2:0]        dcondReg,
  input  logic              accValid,
  input  logic              accIsFetch,
  input  logic              accIsWrite,
  input  logic [1:0]        accSize,
  input  logic              accDataValid,
  input  logic [1:0]        accClass,
  input  logic [1:0]        halfHit,
  output logic              brkReq
);
  logic wrCond, wrDcond;
  logic effFetch, effWrite, effDv;
  logic [1:0] effSize;
  logic kindOk, dirOk, busOk, dataOk, hit;
  logic [1:0] kindSel, dirSel, busSel;

  always_comb begin
    wrCond  = regWrEn && (regAddr == A_COND);
    wrDcond = regWrEn && (regAddr == A_DCOND);
    strb.loadData = regWrEn && (regAddr == A_MDATA);
    strb.loadMask = regWrEn && (regAddr == A_MMASK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      condReg  <= '0;
      dcondReg <= '0;
    end else begin
      if (wrCond)  condReg  <= wrByte & 8'hF7;
      if (wrDcond) dcondReg <= wrByte[2:0];
    end
  end

  // Reclassify cache-control and prefetch instructions
  always_comb begin
    effFetch = accIsFetch;
    effWrite = accIsWrite;
    effSize  = accSize;
    effDv    = accDataValid;
    case (accClass)
      CLS_INVAL: begin effFetch = 1'b0; effWrite = 1'b1; effSize = SZ_LONG; effDv = 1'b0; end
      CLS_PREF:  begin effFetch = 1'b0; effWrite = 1'b0; effSize = SZ_LONG; effDv = 1'b0; end
      default: ;
    endcase
  end

  assign busSel  = condReg[7:6];
  assign kindSel = condReg[5:4];
  assign dirSel  = condReg[2:1];

  always_comb begin
    case (kindSel)
      2'b01:   kindOk = effFetch;
      2'b10:   kindOk = !effFetch;
      default: kindOk = 1'b1;
    endcase
    case (dirSel)
      2'b01:   dirOk = !effWrite;
      2'b10:   dirOk = effWrite;
      default: dirOk = 1'b1;
    endcase
    busOk  = (busSel == 2'b00);
    dataOk = !dcondReg[0] ||
             (effDv && (effSize == dcondReg[2:1]) &&
              halfHit[0] && ((effSize != SZ_QUAD) || halfHit[1]));
    hit = accValid && condReg[0] && kindOk && (effFetch || (busOk && dirOk)) && dataOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) brkReq <= 1'b0;
    else       brkReq <= hit;
  end

  // R3
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    brkReq |-> $past(condReg[0]));
  // R11
  brk_needs_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    brkReq |-> $past(accValid));
  // R6
  bus_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brkReq && !$past(effFetch)) |-> ($past(busSel) == 2'b00));
  // R9
  nodata_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brkReq && $past(dcondReg[0])) |-> ($past(accDataValid) && $past(accClass) != CLS_INVAL && $past(accClass) != CLS_PREF));
  // R10
  inval_not_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    brkReq |-> !($past(accClass) == CLS_INVAL && $past(dirSel) == 2'b01));
endmodule

// File: rtl/dbg_brk_top.sv
module dbg_brk_top
  import dbg_brk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              accValid,
  input  logic              accIsFetch,
  input  logic              accIsWrite,
  input  logic [1:0]        accSize,
  input  logic [2*DATA_W-1:0] accData,
  input  logic              accDataValid,
  input  logic [1:0]        accClass,
  output logic              brkReq
);
  dpStrobe_t strb;
  logic [7:0] condReg;
  logic [2:0] dcondReg;
  logic [DATA_W-1:0] matchData, matchMask;
  logic [1:0] halfHit;

  dbg_brk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .wrByte(regWrData[7:0]), .strb(strb), .condReg(condReg), .dcondReg(dcondReg),
    .accValid(accValid), .accIsFetch(accIsFetch), .accIsWrite(accIsWrite),
    .accSize(accSize), .accDataValid(accDataValid), .accClass(accClass),
    .halfHit(halfHit), .brkReq(brkReq)
  );

  dbg_brk_dp #(.W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData), .accData(accData),
    .matchData(matchData), .matchMask(matchMask), .halfHit(halfHit)
  );

  always_comb begin
    case (regAddr)
      A_COND:  regRdData = {{(DATA_W-8){1'b0}}, condReg};
      A_DCOND: regRdData = {{(DATA_W-3){1'b0}}, dcondReg};
      A_MDATA: regRdData = matchData;
      default: regRdData = matchMask;
    endcase
  end

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == A_COND) |-> (regRdData[3] == 1'b0));
endmodule

// File: tb/tb_dbg_brk_top.sv
`timescale 1ns/1ps
module tb_dbg_brk_top;
  logic clk = 0, rstN = 0;
  logic regWrEn = 0;
  logic [1:0] regAddr = 0;
  logic [31:0] regWrData = 0;
  logic [31:0] regRdData;
  logic accValid = 0, accIsFetch = 0, accIsWrite = 0, accDataValid = 0;
  logic [1:0] accSize = 0, accClass = 0;
  logic [63:0] accData = 0;
  logic brkReq;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] mCond;
  logic [2:0] mDcond;
  logic [31:0] mData, mMask;

  always #2 clk = ~clk;

  dbg_brk_top dut (.*);

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic model(input logic f, input logic w, input logic [1:0] sz,
                                 input logic [63:0] d, input logic dv, input logic [1:0] cls);
    logic kind, dir, dat;
    if (cls == 2'b01) begin f = 0; w = 1; sz = 2'b10; dv = 0; end
    if (cls == 2'b10) begin f = 0; w = 0; sz = 2'b10; dv = 0; end
    if (!mCond[0]) return 0;
    kind = (mCond[5:4] == 2'b01) ? f : (mCond[5:4] == 2'b10) ? !f : 1'b1;
    dir  = (mCond[2:1] == 2'b01) ? !w : (mCond[2:1] == 2'b10) ? w : 1'b1;
    if (!kind) return 0;
    if (!f && (mCond[7:6] != 2'b00 || !dir)) return 0;
    if (mDcond[0]) begin
      dat = dv && (sz == mDcond[2:1]) && (((d[31:0] ^ mData) & ~mMask) == 0);
      if (sz == 2'b11) dat = dat && (((d[63:32] ^ mData) & ~mMask) == 0);
      if (!dat) return 0;
    end
    return 1;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] v);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = v;
    @(negedge clk);
    regWrEn = 0;
    case (a)
      2'd0: mCond = v[7:0] & 8'hF7;
      2'd1: mDcond = v[2:0];
      2'd2: mData = v;
      default: mMask = v;
    endcase
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    regAddr = a;
    #1 chk(regRdData == exp, req, regRdData, exp);
  endtask

  task automatic acc(input logic f, input logic w, input logic [1:0] sz, input logic [63:0] d,
                     input logic dv, input logic [1:0] cls, input string req);
    logic e;
    e = model(f, w, sz, d, dv, cls);
    @(negedge clk);
    accValid = 1; accIsFetch = f; accIsWrite = w; accSize = sz;
    accData = d; accDataValid = dv; accClass = cls;
    @(posedge clk); #1;
    chk(brkReq == e, req, brkReq, e);
    @(negedge clk);
    accValid = 0;
    @(posedge clk); #1;
    chk(brkReq == 0, "R11 single cycle", brkReq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] flip;
    logic [63:0] d;
    void'($urandom(32'h5EED));
    mCond = 0; mDcond = 0; mData = 0; mMask = 0;
    repeat (3) @(posedge clk);
    #1 chk(brkReq == 0, "R1 brkReq reset", brkReq, 0);
    for (int a = 0; a < 4; a++) rd(a[1:0], 0, "R1 reset readback");
    rstN = 1;

    // R2 map and reserved bit
    wr(0, 32'hFFFF_FFFF); rd(0, 32'h0000_00F7, "R2 cond reserved bit");
    wr(1, 32'hFFFF_FFFF); rd(1, 32'h0000_0007, "R2 data cond width");
    wr(2, 32'hDEAD_BEEF); rd(2, 32'hDEAD_BEEF, "R2 match data");
    wr(3, 32'h00FF_00FF); rd(3, 32'h00FF_00FF, "R2 mask");

    // R3 disabled channel
    wr(1, 0); wr(0, 32'h0000_0000);
    acc(0, 0, 2'b10, 0, 1, 0, "R3 disabled operand");
    acc(1, 0, 2'b10, 0, 1, 0, "R3 disabled fetch");
    // R4 kind select
    wr(0, 32'h11); acc(1, 0, 0, 0, 0, 0, "R4 fetch-only fetch");
    acc(0, 0, 0, 0, 0, 0, "R4 fetch-only operand");
    wr(0, 32'h21); acc(1, 0, 0, 0, 0, 0, "R4 operand-only fetch");
    acc(0, 1, 0, 0, 0, 0, "R4 operand-only operand");
    // R5 direction, fetch ignores it
    wr(0, 32'h03); acc(0, 1, 0, 0, 0, 0, "R5 read-only write");
    acc(0, 0, 0, 0, 0, 0, "R5 read-only read");
    acc(1, 1, 0, 0, 0, 0, "R5 fetch ignores direction");
    // R6 bus select
    wr(0, 32'h41); acc(0, 0, 0, 0, 0, 0, "R6 reserved bus operand");
    acc(1, 0, 0, 0, 0, 0, "R6 reserved bus fetch");
    // R7 / R8 data
    wr(0, 32'h01); wr(2, 32'h1234_5678); wr(3, 32'h0000_00FF); wr(1, 32'h7);
    acc(0, 0, 2'b11, 64'h1234_5600_1234_56AA, 1, 0, "R8 quad both halves");
    acc(0, 0, 2'b11, 64'h9234_5678_1234_5678, 1, 0, "R8 quad upper mismatch");
    acc(0, 0, 2'b11, 64'h1234_5678_1134_5678, 1, 0, "R8 quad lower mismatch");
    wr(1, 32'h5);
    acc(0, 0, 2'b10, 64'hFFFF_FFFF_1234_5611, 1, 0, "R7 long masked");
    acc(0, 0, 2'b10, 64'h0000_0000_1234_4678, 1, 0, "R7 long unmasked bit");
    // R9 size and data presence
    acc(0, 0, 2'b01, 64'h0000_0000_1234_5678, 1, 0, "R9 wrong size");
    acc(0, 0, 2'b10, 64'h0000_0000_1234_5678, 0, 0, "R9 no data");
    // R10 classes
    acc(0, 0, 2'b10, 64'h0000_0000_1234_5678, 1, 2'b01, "R10 inval with data cond");
    wr(1, 0); wr(0, 32'h03);
    acc(1, 0, 0, 0, 0, 2'b01, "R10 inval vs read-only");
    acc(1, 1, 0, 0, 0, 2'b10, "R10 pref vs read-only");
    wr(0, 32'h05); acc(1, 0, 0, 0, 0, 2'b01, "R10 inval vs write-only");
    wr(0, 32'h11); acc(1, 0, 0, 0, 0, 2'b10, "R10 pref not fetch");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      if (i % 8 == 0) begin
        wr(0, {24'd0, (($urandom % 4 == 0) ? 2'($urandom) : 2'b00), 4'($urandom),
                ($urandom % 6 != 0)});
        wr(1, 32'($urandom % 8));
        wr(2, $urandom);
        wr(3, $urandom & $urandom);
      end
      if ($urandom % 2 == 0) begin
        flip = $urandom & mMask;
        d = {mData ^ (($urandom % 4 == 0) ? $urandom : flip), mData ^ flip};
      end else d = {$urandom, $urandom};
      acc($urandom % 2, $urandom % 2, 2'($urandom), d, $urandom % 4 != 0,
          (($urandom % 4 == 0) ? 2'($urandom) : 2'b00), "R7 R8 R4 R5 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule